// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Resolver

This block gathers every pending reason to interrupt a 16-bit processor core and picks the single one that the sequencer services next. There are six sources: an instruction exception, a single-step trap, a non-maskable request, a coprocessor segment overrun, a maskable external request, and a software interrupt instruction. For the winner it outputs an 8-bit vector type and the byte address of that type's 4-byte entry in the vector table. It also reports whether an external acknowledge cycle has to run to fetch the type, and which return address is to be saved.

Selection is purely combinational and takes effect in the cycle its inputs are present. Apart from exceptions, a request is considered only while the instruction-boundary strobe is high. The non-maskable input is edge-sensitive. Its rising edge is held in a pending flag until the sequencer accepts that request. The sequencer confirms a service by raising `accept` while the grant is shown.

Top module: `intResolver`

## Requirements
- R1: An asserted `excReq` wins in any cycle, whether or not `boundary` is high. It gives `srcSel`=1 and `vecType`=`excType`. For example, a divide error is type 0 and a coprocessor error is type 16.
- R2: When `boundary` and `tfFlag` are both high and no exception is present, the grant is single step, with `srcSel`=2 and `vecType`=1.
- R3: A rising edge on `nmiIn` makes the non-maskable request pending from the next clock onward. At a boundary, with no exception or step present, it wins with `srcSel`=3 and `vecType`=2, whatever the value of `ifFlag`. `needAck` stays 0.
- R4: The non-maskable request stays pending until a cycle in which it is the grant and `accept` is high. A further edge that arrives while it is pending merges into it, so only one service results. Accepting a different source leaves it pending.
- R5: A coprocessor segment overrun (`ovrReq`) wins below the non-maskable request, with `srcSel`=4 and `vecType`=9.
- R6: `intrReq` is ignored while `ifFlag` is 0. When it wins, `srcSel`=5, `vecType`=`intrType`, and `needAck`=1. `needAck` is 0 for every other grant.
- R7: A software interrupt (`swReq`) has the lowest rank, with `srcSel`=6 and `vecType`=`swType` over the full range 0 to 255.
- R8: When `boundary` is 0 and `excReq` is 0, `intValid` is 0 and `srcSel` is 0.
- R9: `vecAddr` equals `vecType` times 4, which spans 0x000 to 0x3FC.
- R10: `retAddr` equals `curPc` (the faulting instruction) for an exception grant and `nextPc` for any other grant.
- R11: While `rstN` is low and after reset, no source is pending. With `boundary` high and no request present, `intValid` is 0.
- R12: The fixed rank is exception, then single step, then non-maskable, then segment overrun, then external maskable, then software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Instruction exception present |
| excType | input | 8 | Type of the exception |
| tfFlag | input | 1 | Trap flag (single step enable) |
| ifFlag | input | 1 | Interrupt-enable flag |
| nmiIn | input | 1 | Non-maskable request, rising-edge sensitive |
| ovrReq | input | 1 | Coprocessor segment overrun request |
| intrReq | input | 1 | Maskable external request |
| intrType | input | 8 | Type supplied on the data input for the external request |
| swReq | input | 1 | Software interrupt instruction executing |
| swType | input | 8 | Operand of the software interrupt |
| boundary | input | 1 | Instruction boundary strobe |
| accept | input | 1 | Sequencer takes the current grant |
| curPc | input | 16 | Address of the current instruction |
| nextPc | input | 16 | Address of the following instruction |
| intValid | output | 1 | A grant is shown |
| srcSel | output | 3 | Granted source code (0 none, 1 to 6 as in the requirements) |
| vecType | output | 8 | Vector type of the grant |
| vecAddr | output | 10 | Vector table byte address |
| needAck | output | 1 | An external acknowledge cycle is required |
| retAddr | output | 16 | Return address to save |

## Verification
The central collision is between a pending non-maskable request and a same-cycle exception or trap. The bench raises the edge first and then presents a boundary together with `excReq` or `tfFlag`. It judges that the higher source wins and that the non-maskable request is still shown once the higher source drops. A second collision is between the acknowledge and a new edge. A repeated edge is injected while the request is pending, then a single accept is given, and the bench checks that no second grant appears.

// File: rtl/intres_pkg.sv
package intres_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_EXC  = 3'd1,
    SRC_STEP = 3'd2,
    SRC_NMI  = 3'd3,
    SRC_OVR  = 3'd4,
    SRC_INTR = 3'd5,
    SRC_SW   = 3'd6
  } srcSel_e;

  typedef struct packed {
    logic    grant;
    srcSel_e src;
    logic    useFault;
  } ctlStrobe_t;
endpackage

// File: rtl/intres_ctrl.sv
module intres_ctrl
  import intres_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       excReq,
  input  logic       tfFlag,
  input  logic       ifFlag,
  input  logic       nmiIn,
  input  logic       ovrReq,
  input  logic       intrReq,
  input  logic       swReq,
  input  logic       boundary,
  input  logic       accept,
  output ctlStrobe_t ctl,
  output logic       needAck
);
  logic nmiPrev, nmiPend, nmiRise, nmiTaken;

  assign nmiRise = nmiIn & ~nmiPrev;

  // fixed rank; only exceptions bypass the boundary strobe
  always_comb begin
    ctl.src = SRC_NONE;
    if (excReq)                               ctl.src = SRC_EXC;
    else if (boundary) begin
      if (tfFlag)                             ctl.src = SRC_STEP;
      else if (nmiPend)                       ctl.src = SRC_NMI;
      else if (ovrReq)                        ctl.src = SRC_OVR;
      else if (intrReq && ifFlag)             ctl.src = SRC_INTR;
      else if (swReq)                         ctl.src = SRC_SW;
    end
    ctl.grant    = (ctl.src != SRC_NONE);
    ctl.useFault = (ctl.src == SRC_EXC);
  end

  assign needAck  = (ctl.src == SRC_INTR);
  assign nmiTaken = accept && (ctl.src == SRC_NMI);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiIn;
      nmiPend <= (nmiPend & ~nmiTaken) | nmiRise;
    end
  end

  p_nmi_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    nmiRise |=> nmiPend);
  p_nmi_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && !nmiTaken) |=> nmiPend);
  p_ack_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    needAck |-> (intrReq && ifFlag && boundary));
  p_idle_off_boundary_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!boundary && !excReq) |-> !ctl.grant);
  p_exc_wins_r1: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (ctl.useFault && !needAck));
endmodule

// File: rtl/intres_dpath.sv
module intres_dpath
  import intres_pkg::*;
#(
  parameter int TYPE_W      = 8,
  parameter int PC_W        = 16,
  parameter int ENTRY_BYTES = 4,
  parameter int STEP_TYPE   = 1,
  parameter int NMI_TYPE    = 2,
  parameter int OVR_TYPE    = 9,
  localparam int OFS_W      = $clog2(ENTRY_BYTES),
  localparam int ADDR_W     = TYPE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [TYPE_W-1:0] excType,
  input  logic [TYPE_W-1:0] intrType,
  input  logic [TYPE_W-1:0] swType,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PC_W-1:0]   nextPc,
  output logic [TYPE_W-1:0] vecType,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [PC_W-1:0]   retAddr
);
  always_comb begin
    unique case (ctl.src)
      SRC_EXC:  vecType = excType;
      SRC_STEP: vecType = TYPE_W'(STEP_TYPE);
      SRC_NMI:  vecType = TYPE_W'(NMI_TYPE);
      SRC_OVR:  vecType = TYPE_W'(OVR_TYPE);
      SRC_INTR: vecType = intrType;
      SRC_SW:   vecType = swType;
      default:  vecType = '0;
    endcase
  end

  generate
    if (OFS_W > 0) begin : g_scaled
      assign vecAddr = {vecType, {OFS_W{1'b0}}};
    end else begin : g_flat
      assign vecAddr = vecType;
    end
  endgenerate

  assign retAddr = ctl.useFault ? curPc : nextPc;

  p_fixed_types_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.src == SRC_STEP) |-> (vecAddr == ADDR_W'(STEP_TYPE * ENTRY_BYTES)));
  p_nmi_type_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.src == SRC_NMI) |-> (vecAddr == ADDR_W'(NMI_TYPE * ENTRY_BYTES)));
  p_ret_next_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.grant && ctl.src != SRC_EXC) |-> (retAddr == nextPc));
endmodule

// File: rtl/intResolver.sv
module intResolver
  import intres_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int PC_W   = 16,
  localparam int ADDR_W = TYPE_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [TYPE_W-1:0] excType,
  input  logic              tfFlag,
  input  logic              ifFlag,
  input  logic              nmiIn,
  input  logic              ovrReq,
  input  logic              intrReq,
  input  logic [TYPE_W-1:0] intrType,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic              boundary,
  input  logic              accept,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PC_W-1:0]   nextPc,
  output logic              intValid,
  output logic [2:0]        srcSel,
  output logic [TYPE_W-1:0] vecType,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              needAck,
  output logic [PC_W-1:0]   retAddr
);
  ctlStrobe_t ctl;

  intres_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .tfFlag(tfFlag), .ifFlag(ifFlag),
    .nmiIn(nmiIn), .ovrReq(ovrReq), .intrReq(intrReq), .swReq(swReq),
    .boundary(boundary), .accept(accept), .ctl(ctl), .needAck(needAck)
  );

  intres_dpath #(.TYPE_W(TYPE_W), .PC_W(PC_W), .ENTRY_BYTES(4)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .excType(excType), .intrType(intrType),
    .swType(swType), .curPc(curPc), .nextPc(nextPc),
    .vecType(vecType), .vecAddr(vecAddr), .retAddr(retAddr)
  );

  assign intValid = ctl.grant;
  assign srcSel   = ctl.src;
endmodule

// File: tb/intResolver_tb.sv
`timescale 1ns/100ps
module intResolver_tb;
  logic clk = 0, rstN = 0;
  logic excReq = 0, tfFlag = 0, ifFlag = 0, nmiIn = 0, ovrReq = 0, intrReq = 0, swReq = 0;
  logic boundary = 0, accept = 0;
  logic [7:0] excType = 0, intrType = 0, swType = 0;
  logic [15:0] curPc = 16'h1234, nextPc = 16'h1236;
  logic intValid, needAck;
  logic [2:0] srcSel;
  logic [7:0] vecType;
  logic [9:0] vecAddr;
  logic [15:0] retAddr;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  intResolver u_dut (.*);

  typedef struct packed {
    logic exc; logic [7:0] et; logic tf, ie, ovr, intr; logic [7:0] it;
    logic sw; logic [7:0] st; logic bnd;
    logic ev; logic [7:0] ety; logic [2:0] es; logic ea;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd0,  1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b0, 8'h00, 1'b0,  1'b1, 8'd0,  3'd1, 1'b0}, // R1 off boundary
    '{1'b1, 8'd16, 1'b1,1'b1,1'b1,1'b1, 8'h20, 1'b1, 8'h80, 1'b1,  1'b1, 8'd16, 3'd1, 1'b0}, // R1 R12
    '{1'b0, 8'd0,  1'b1,1'b1,1'b1,1'b1, 8'h20, 1'b1, 8'h80, 1'b1,  1'b1, 8'd1,  3'd2, 1'b0}, // R2
    '{1'b0, 8'd0,  1'b1,1'b1,1'b1,1'b1, 8'h20, 1'b1, 8'h80, 1'b0,  1'b0, 8'd0,  3'd0, 1'b0}, // R8
    '{1'b0, 8'd0,  1'b0,1'b1,1'b1,1'b1, 8'h20, 1'b1, 8'h80, 1'b1,  1'b1, 8'd9,  3'd4, 1'b0}, // R5
    '{1'b0, 8'd0,  1'b0,1'b1,1'b0,1'b1, 8'h20, 1'b1, 8'h80, 1'b1,  1'b1, 8'h20, 3'd5, 1'b1}, // R6
    '{1'b0, 8'd0,  1'b0,1'b0,1'b0,1'b1, 8'h20, 1'b1, 8'h80, 1'b1,  1'b1, 8'h80, 3'd6, 1'b0}, // R6 masked
    '{1'b0, 8'd0,  1'b0,1'b0,1'b0,1'b1, 8'h20, 1'b0, 8'h00, 1'b1,  1'b0, 8'd0,  3'd0, 1'b0}, // R6 ignored
    '{1'b0, 8'd0,  1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b1, 8'hFF, 1'b1,  1'b1, 8'hFF, 3'd6, 1'b0}, // R7 R9 top
    '{1'b0, 8'd0,  1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b1, 8'h00, 1'b1,  1'b1, 8'h00, 3'd6, 1'b0}, // R7 R9 zero
    '{1'b0, 8'd0,  1'b0,1'b1,1'b0,1'b1, 8'hFF, 1'b0, 8'h00, 1'b1,  1'b1, 8'hFF, 3'd5, 1'b1}, // R6
    '{1'b0, 8'd0,  1'b0,1'b1,1'b0,1'b0, 8'h00, 1'b0, 8'h00, 1'b1,  1'b0, 8'd0,  3'd0, 1'b0}  // R11 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkGrant(input string req, input logic ev, input logic [2:0] es,
                            input logic [7:0] ety, input logic ea);
    chk({req, " valid"}, intValid, ev);
    chk({req, " src"}, srcSel, es);
    chk({req, " ack"}, needAck, ea);
    if (ev) begin
      chk({req, " type"}, vecType, ety);
      chk({req, " R9 addr"}, vecAddr, {ety, 2'b00});
      chk({req, " R10 ret"}, retAddr, (es == 3'd1) ? curPc : nextPc);
    end
  endtask

  task automatic clearIn();
    excReq = 0; tfFlag = 0; ifFlag = 0; ovrReq = 0; intrReq = 0; swReq = 0;
    boundary = 0; accept = 0;
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); boundary = 1; #1;
    checkGrant("R11 in reset", 1'b0, 3'd0, 8'd0, 1'b0);
    @(negedge clk); rstN = 1; #1;
    checkGrant("R11 after reset", 1'b0, 3'd0, 8'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      excReq = VECS[i].exc; excType = VECS[i].et; tfFlag = VECS[i].tf; ifFlag = VECS[i].ie;
      ovrReq = VECS[i].ovr; intrReq = VECS[i].intr; intrType = VECS[i].it;
      swReq = VECS[i].sw; swType = VECS[i].st; boundary = VECS[i].bnd;
      #1;
      checkGrant($sformatf("R12 vec%0d", i), VECS[i].ev, VECS[i].es, VECS[i].ety, VECS[i].ea);
    end

    // R3: edge latched, off boundary no grant, IF=0 does not mask
    @(negedge clk); clearIn(); nmiIn = 1; #1;
    checkGrant("R3 same cycle", 1'b0, 3'd0, 8'd0, 1'b0);
    @(negedge clk); #1;
    checkGrant("R8 nmi pending off boundary", 1'b0, 3'd0, 8'd0, 1'b0);
    @(negedge clk); boundary = 1; ovrReq = 1; intrReq = 1; ifFlag = 0; #1;
    checkGrant("R3 nmi", 1'b1, 3'd3, 8'd2, 1'b0);
    // R12: exception and step above pending nmi
    @(negedge clk); excReq = 1; excType = 8'd0; #1;
    checkGrant("R12 exc over nmi", 1'b1, 3'd1, 8'd0, 1'b0);
    @(negedge clk); accept = 1; #1;   // accepting exception must not clear nmi (R4)
    @(negedge clk); accept = 0; excReq = 0; tfFlag = 1; #1;
    checkGrant("R12 step over nmi", 1'b1, 3'd2, 8'd1, 1'b0);
    @(negedge clk); tfFlag = 0; #1;
    checkGrant("R4 still pending", 1'b1, 3'd3, 8'd2, 1'b0);
    // R4: second edge merges
    @(negedge clk); nmiIn = 0;
    @(negedge clk); nmiIn = 1;
    @(negedge clk); #1;
    checkGrant("R4 merged pending", 1'b1, 3'd3, 8'd2, 1'b0);
    @(negedge clk); accept = 1;
    @(negedge clk); accept = 0; #1;
    checkGrant("R4 after accept", 1'b1, 3'd4, 8'd9, 1'b0);
    @(negedge clk); ovrReq = 0; #1;
    checkGrant("R4 single service", 1'b0, 3'd0, 8'd0, 1'b0);

    @(negedge clk); clearIn(); nmiIn = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule